// File: doc/BRIEF.md
# Chip-Select Window Address Matcher

This block holds the setup of eight external-bus chip-select windows and, given an address, reports which window covers it. Each window has an enable, a base field in 64 KiB units, a size field that means "size + 1" units, and a bus-width flag. Software-facing logic or a boot controller loads the windows through a simple write port. A lookup is started by presenting an address with a valid strobe. One clock later the block reports whether a window matched, its index, its start address and byte length, and the width flag.

Several windows may cover the same address. In that case the enabled window with the smallest index is chosen. For devices that use two adjacent windows together, the block also reports whether the window after the selected one is enabled. It further reports whether the matched window can act as the first half of a pair. A pair cannot start at the last window. When the address is aligned to 64 KiB, a pair also needs the next window to be enabled.

Top module: `cs_region_matcher`

## Requirements
- R1: After reset, out_valid, out_hit, out_idx, out_start, out_len, out_wide, out_next_en and out_pair_ok are all 0, and every window is disabled.
- R2: When cfg_we is high at a clock edge, window cfg_idx takes cfg_en, cfg_base, cfg_size and cfg_wide. Every lookup presented after that edge uses the new setting.
- R3: For a matched window, out_start equals its base field shifted left by 16, and out_len equals (size field + 1) shifted left by 16.
- R4: A window matches only when it is enabled and start ≤ address < start + length. The end bound is computed without wrap-around, so a window that ends at the top of the address space still matches its last address.
- R5: When several enabled windows match, the lowest index is reported.
- R6: When no window matches, out_hit, out_idx, out_start, out_len, out_wide, out_next_en and out_pair_ok are all 0.
- R7: out_wide carries the width flag of the selected window.
- R8: out_next_en is the enable of window out_idx+1 when a window matched below index 7, and 0 otherwise.
- R9: out_pair_ok is 1 only when a window matched, its index is below 7, and either the address bits [15:0] are not all zero or the next window is enabled.
- R10: out_valid rises one cycle after in_valid and is 0 one cycle after a cycle without in_valid. While no lookup is presented, the result outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Window setup write strobe |
| cfg_idx | input | 3 | Window written |
| cfg_en | input | 1 | Enable for the written window |
| cfg_base | input | 16 | Base in 64 KiB units |
| cfg_size | input | 12 | Size in 64 KiB units, minus one |
| cfg_wide | input | 1 | Width flag (1 = 16-bit bus) |
| in_valid | input | 1 | Lookup strobe |
| in_addr | input | 32 | Address looked up |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_hit | output | 1 | A window matched |
| out_idx | output | 3 | Matched window index, 0 on a miss |
| out_start | output | 32 | Matched window start address |
| out_len | output | 32 | Matched window byte length |
| out_wide | output | 1 | Matched window width flag |
| out_next_en | output | 1 | Enable of the following window |
| out_pair_ok | output | 1 | Matched window can start a pair |

## Verification
The bench loads a fixed set of eight windows. This set contains a disabled window, two overlapping windows, and a last window that reaches the top of the address space. Lookup addresses sit on the first and last byte of windows and one byte outside them. These show whether both ends of the range compare correctly and whether the end bound wraps. Addresses in the overlap show which window has priority. Addresses inside the disabled window show whether the enable is honoured. Aligned and unaligned addresses in windows whose neighbour is enabled or disabled, and in the last window, tell the pair rules apart. A window is then rewritten to confirm that setup changes reach the next lookup.

// File: rtl/cs_match_pkg.sv
package cs_match_pkg;
    localparam int NUM_WIN  = 8;
    localparam int IDX_W    = $clog2(NUM_WIN);
    localparam int ADDR_W   = 32;
    localparam int UNIT_SH  = 16;
    localparam int BASE_W   = ADDR_W - UNIT_SH;
    localparam int SIZE_W   = 12;

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic              wide;
    } win_cfg_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] len;
        logic              wide;
        logic              next_en;
        logic              pair_ok;
    } match_res_t;
endpackage

// File: rtl/cs_window_cmp.sv
module cs_window_cmp
    import cs_match_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              match,
    output logic [ADDR_W-1:0] start,
    output logic [ADDR_W-1:0] len
);
    logic [ADDR_W:0] end_x;

    always_comb begin
        start = ADDR_W'(cfg.base) << UNIT_SH;
        len   = (ADDR_W'(cfg.size) + ADDR_W'(1)) << UNIT_SH;
        // one extra bit so a window reaching the top of the space does not wrap
        end_x = {1'b0, start} + {1'b0, len};
        match = cfg.en && (addr >= start) && ({1'b0, addr} < end_x);
    end
endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick
    import cs_match_pkg::*;
(
    input  logic [NUM_WIN-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   sel
);
    always_comb begin
        any = |req;
        sel = '0;
        // walk from the top so the lowest set index is the one that remains
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (req[i]) sel = IDX_W'(i);
        end
    end
endmodule

// File: rtl/cs_region_matcher.sv
module cs_region_matcher
    import cs_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              cfg_wide,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [IDX_W-1:0]  out_idx,
    output logic [ADDR_W-1:0] out_start,
    output logic [ADDR_W-1:0] out_len,
    output logic              out_wide,
    output logic              out_next_en,
    output logic              out_pair_ok
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WIN - 1);

    win_cfg_t   cfg_d [NUM_WIN];
    win_cfg_t   cfg_q [NUM_WIN];
    match_res_t res_d, res_q;

    logic [NUM_WIN-1:0] win_match;
    logic [ADDR_W-1:0]  win_start [NUM_WIN];
    logic [ADDR_W-1:0]  win_len   [NUM_WIN];
    logic               any_hit;
    logic [IDX_W-1:0]   hit_idx;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        cs_window_cmp i_cmp (
            .cfg   (cfg_q[g]),
            .addr  (in_addr),
            .match (win_match[g]),
            .start (win_start[g]),
            .len   (win_len[g])
        );
    end

    cs_prio_pick i_pick (
        .req (win_match),
        .any (any_hit),
        .sel (hit_idx)
    );

    always_comb begin
        logic nxt;
        for (int i = 0; i < NUM_WIN; i++) begin
            cfg_d[i] = cfg_q[i];
            if (cfg_we && cfg_idx == IDX_W'(i)) begin
                cfg_d[i].en   = cfg_en;
                cfg_d[i].base = cfg_base;
                cfg_d[i].size = cfg_size;
                cfg_d[i].wide = cfg_wide;
            end
        end

        nxt = 1'b0;
        if (hit_idx != LAST_IDX) nxt = cfg_q[hit_idx + IDX_W'(1)].en;

        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.hit     = any_hit;
            res_d.idx     = any_hit ? hit_idx : '0;
            res_d.start   = any_hit ? win_start[hit_idx] : '0;
            res_d.len     = any_hit ? win_len[hit_idx] : '0;
            res_d.wide    = any_hit && cfg_q[hit_idx].wide;
            res_d.next_en = any_hit && nxt;
            res_d.pair_ok = any_hit && (hit_idx != LAST_IDX)
                            && ((in_addr[UNIT_SH-1:0] != '0) || nxt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            for (int i = 0; i < NUM_WIN; i++) cfg_q[i] <= '0;
        end else begin
            res_q <= res_d;
            for (int i = 0; i < NUM_WIN; i++) cfg_q[i] <= cfg_d[i];
        end
    end

    assign out_valid   = res_q.valid;
    assign out_hit     = res_q.hit;
    assign out_idx     = res_q.idx;
    assign out_start   = res_q.start;
    assign out_len     = res_q.len;
    assign out_wide    = res_q.wide;
    assign out_next_en = res_q.next_en;
    assign out_pair_ok = res_q.pair_ok;

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_hit) && $stable(out_idx) && $stable(out_len)));
    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_idx == '0 && out_len == '0 && !out_pair_ok && !out_next_en));
    // R9
    pair_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_pair_ok |-> (out_hit && out_idx != LAST_IDX));
    // R3
    len_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (out_len != '0 && out_len[UNIT_SH-1:0] == '0 && out_start[UNIT_SH-1:0] == '0));
endmodule

// File: tb/test_cs_region_matcher.sv
module test_cs_region_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic [15:0] cfg_base = '0;
    logic [11:0] cfg_size = '0;
    logic        cfg_wide = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid, out_hit, out_wide, out_next_en, out_pair_ok;
    logic [2:0]  out_idx;
    logic [31:0] out_start, out_len;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_base [8];
    logic [11:0] m_size [8];

    always #5 clk = ~clk;

    cs_region_matcher i_cs_region_matcher (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_wide(cfg_wide), .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_idx(out_idx),
        .out_start(out_start), .out_len(out_len), .out_wide(out_wide),
        .out_next_en(out_next_en), .out_pair_ok(out_pair_ok)
    );

    // {addr, hit, idx, wide, next_en, pair_ok}
    typedef struct packed {
        logic [31:0] addr;
        logic        hit;
        logic [2:0]  idx;
        logic        wide;
        logic        nxt;
        logic        pair;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{32'h0010_0000, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1},
        '{32'h0010_FFFF, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1},
        '{32'h0011_0000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
        '{32'h000F_FFFF, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
        '{32'h0020_0000, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0},
        '{32'h0021_0004, 1'b1, 3'd1, 1'b1, 1'b0, 1'b1},
        '{32'h0023_FFFF, 1'b1, 3'd1, 1'b1, 1'b0, 1'b1},
        '{32'h0024_0000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
        '{32'h0030_0010, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
        '{32'h0040_0000, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0},
        '{32'h0041_FFF0, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1},
        '{32'h0060_0000, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1},
        '{32'hFFFF_0000, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0},
        '{32'hFFFF_FFFF, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_win(input int i, input bit en, input logic [15:0] b,
                             input logic [11:0] s, input bit w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_en = en;
        cfg_base = b; cfg_size = s; cfg_wide = w;
        m_base[i] = b; m_size[i] = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_res(input string tag, input bit hit, input logic [2:0] idx,
                              input bit wide, input bit nxt, input bit pair);
        logic [31:0] es, el;
        es = hit ? ({16'h0, m_base[idx]} << 16) : 32'h0;
        el = hit ? (({20'h0, m_size[idx]} + 32'd1) << 16) : 32'h0;
        check(tag, "valid R10", {31'h0, out_valid}, 32'd1);
        check(tag, "hit R4", {31'h0, out_hit}, {31'h0, hit});
        check(tag, "idx R5", {29'h0, out_idx}, {29'h0, idx});
        check(tag, "start R3", out_start, es);
        check(tag, "len R3", out_len, el);
        check(tag, "wide R7", {31'h0, out_wide}, {31'h0, wide});
        check(tag, "next R8", {31'h0, out_next_en}, {31'h0, nxt});
        check(tag, "pair R9", {31'h0, out_pair_ok}, {31'h0, pair});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "valid", {31'h0, out_valid}, 32'd0);
        check("R1", "hit", {31'h0, out_hit}, 32'd0);
        check("R1", "len", out_len, 32'd0);
        rst_n = 1'b1;
        // R1: windows disabled after reset
        lookup(32'h0000_0000);
        expect_res("R1", 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);

        // R2: load window setup
        write_win(0, 1, 16'h0010, 12'd0, 0);
        write_win(1, 1, 16'h0020, 12'd3, 1);
        write_win(2, 0, 16'h0030, 12'd0, 0);
        write_win(3, 1, 16'h0021, 12'd0, 0);
        write_win(4, 1, 16'h0040, 12'd1, 0);
        write_win(5, 0, 16'h0050, 12'd0, 0);
        write_win(6, 1, 16'h0060, 12'd0, 1);
        write_win(7, 1, 16'hFFFF, 12'hFFF, 0);

        // R4 R5 R6 R7 R8 R9 table walk
        for (int v = 0; v < 14; v++) begin
            lookup(VECS[v].addr);
            expect_res($sformatf("vec%0d R4", v), VECS[v].hit, VECS[v].idx,
                       VECS[v].wide, VECS[v].nxt, VECS[v].pair);
        end

        // R6: miss clears everything even after a hit
        lookup(32'h0060_0000);
        lookup(32'h0800_0000);
        expect_res("R6", 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);

        // R10: no lookup -> out_valid low, results held
        lookup(32'h0020_0000);
        @(negedge clk);
        check("R10", "valid low", {31'h0, out_valid}, 32'd0);
        check("R10", "idx held", {29'h0, out_idx}, 32'd1);
        check("R10", "hit held", {31'h0, out_hit}, 32'd1);

        // R2: enabling window 2 changes next-enable and pair of window 1, and hits window 2
        write_win(2, 1, 16'h0030, 12'd0, 1);
        lookup(32'h0020_0000);
        expect_res("R2", 1'b1, 3'd1, 1'b1, 1'b1, 1'b1);
        lookup(32'h0030_0010);
        expect_res("R2", 1'b1, 3'd2, 1'b1, 1'b1, 1'b1);

        // R5: disabling window 1 lets window 3 win in the overlap
        write_win(1, 0, 16'h0020, 12'd3, 1);
        lookup(32'h0021_0004);
        expect_res("R5", 1'b1, 3'd3, 1'b0, 1'b1, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule